// File: doc/BRIEF.md
# Tri-State Aware Pin Trace Capture

This block records the activity of a bank of bidirectional pins. Each pin brings three signals into the block: the value received from the pad, the value the chip drives toward the pad, and the direction control that picks between them. On every sample event the block builds one word with one bit per pin. A pin that is currently tri-stated contributes its received value. A pin that is currently driving contributes its driven value. One word can therefore mix inputs and outputs, and the choice follows the live direction of each pin.

A capture starts on a `start` pulse. In single-shot mode it takes a programmed number of samples and then ends with a one-cycle `done` pulse. In continuous mode it runs until it is stopped. Sample events normally come from `sample_tick`, which is the same enable that advances the pattern and state-machine generators. In step mode, events come only from `step` pulses. Each pin can belong to one or more source blocks. A per-source trace enable masks the pins whose owners all have tracing off.

Words leave through a valid/ready stream with a last marker that stands in for the path to memory. The output register holds one word. The word stays stable until the consumer accepts it. If a new sample falls due while the held word has not been accepted, the new sample is dropped and a sticky overflow flag is set. If the held word is accepted in the same cycle that a new sample falls due, the new word is loaded and nothing is lost.

Top module: `trc_capture`

## Requirements
- R1: After reset, `m_tvalid`, `busy`, `done` and `overflow` are 0.
- R2: Bit p of a captured word is `pin_in[p]` when `pin_hiz[p]` is 1, and `pin_out[p]` when `pin_hiz[p]` is 0. The choice is made for each pin separately, within the same sample.
- R3: Bit p is 0 unless at least one source s has `src_mask[s*NUM_PINS+p]`=1 and its trace enable set. The trace enables reset to all ones, and `trace_wr` loads them from `trace_wdata`.
- R4: A single-shot run (`cfg_cont`=0) with count N>0 takes exactly one sample per event, N samples in total. On the edge that takes the last sample, `busy` falls and `done` pulses for one cycle. `done` appears in the same cycle as the last word's `m_tvalid`.
- R5: `m_tlast` is 1 only on the final word of a single-shot run, and never in continuous mode.
- R6: A start with count 0 in single-shot mode takes no sample. `done` is 1 in the cycle after the start, and `busy` stays 0.
- R7: After `stop`, the first sample event, including one in the same cycle as `stop`, ends the run. That event emits no word, drops `busy` and pulses `done`.
- R8: While `step_mode` is 1, only `step` pulses take samples and `sample_tick` has no effect.
- R9: While `m_tvalid`=1 and `m_tready`=0, `m_tdata` and `m_tlast` hold. A sample due in that state is dropped and sets `overflow`. `overflow` stays set until the next accepted start clears it.
- R10: A sample due in the same cycle that the held word is accepted is loaded as the next word and does not set `overflow`.
- R11: `start` while `busy` is ignored.
- R12: In continuous mode (`cfg_cont`=1) the count is ignored and capture continues until stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Sample clock enable shared with the generators |
| pin_in | input | NUM_PINS | Values received from the pads |
| pin_out | input | NUM_PINS | Values driven toward the pads |
| pin_hiz | input | NUM_PINS | 1 = pin tri-stated (input), 0 = pin driving |
| src_mask | input | NUM_SRC*NUM_PINS | Pin ownership, bit s*NUM_PINS+p set if source s owns pin p |
| trace_wr | input | 1 | Load strobe for the trace enables |
| trace_wdata | input | NUM_SRC | New trace enables, one per source |
| start | input | 1 | Start pulse, accepted only when idle |
| stop | input | 1 | Stop request pulse |
| cfg_count | input | CNT_W | Number of samples for a single-shot run |
| cfg_cont | input | 1 | 1 = continuous run |
| step_mode | input | 1 | 1 = samples taken on step pulses only |
| step | input | 1 | Single-step pulse |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Sticky dropped-sample flag |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream consumer ready |
| m_tdata | output | NUM_PINS | Captured pin word |
| m_tlast | output | 1 | Final word of a single-shot run |

## Verification
Two collisions are provoked on purpose. In the first, the consumer raises `m_tready` on the held word in exactly the cycle that a new tick arrives. The bench then expects both words in order and `overflow` still clear. In the second, a stop request and the next tick share a cycle, or the request waits for the tick. The bench then expects `done` with no extra word, and `busy` still high in the cycles before that tick. A scoreboard queue judges every delivered word and its last marker. It also flags any word delivered while the queue is empty.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } trc_state_e;
endpackage

// File: rtl/trc_pin_select.sv
module trc_pin_select #(
  parameter int NUM_PINS = 20,
  parameter int NUM_SRC  = 3
) (
  input  logic [NUM_PINS-1:0]         pin_in,
  input  logic [NUM_PINS-1:0]         pin_out,
  input  logic [NUM_PINS-1:0]         pin_hiz,
  input  logic [NUM_SRC*NUM_PINS-1:0] src_mask,
  input  logic [NUM_SRC-1:0]          trace_en,
  output logic [NUM_PINS-1:0]         word
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_SRC-1:0] owner_on;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign owner_on[s] = src_mask[s*NUM_PINS + p] & trace_en[s];
    end
    // direction picks received or driven value
    assign word[p] = (|owner_on) ? (pin_hiz[p] ? pin_in[p] : pin_out[p]) : 1'b0;
  end
endmodule

// File: rtl/trc_seq.sv
module trc_seq
  import trc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_cont,
  input  logic             step_mode,
  input  logic             step,
  input  logic             tick,
  output logic             take,
  output logic             take_last,
  output logic             start_ok,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  trc_state_e       state;
  logic [CNT_W-1:0] rem;
  logic             cont_q;
  logic             stop_pend;
  logic             done_q;
  logic             evt;
  logic             eff_stop;

  assign busy      = (state == ST_RUN);
  assign evt       = busy && (step_mode ? step : tick);
  assign eff_stop  = stop || stop_pend;
  assign take      = evt && !eff_stop;
  assign take_last = take && !cont_q && (rem == ONE);
  assign start_ok  = (state == ST_IDLE) && start;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rem       <= '0;
      cont_q    <= 1'b0;
      stop_pend <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            stop_pend <= 1'b0;
            cont_q    <= cfg_cont;
            rem       <= cfg_count;
            if (!cfg_cont && (cfg_count == '0)) done_q <= 1'b1;
            else                                state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (evt) begin
            if (eff_stop) begin
              state     <= ST_IDLE;
              stop_pend <= 1'b0;
              done_q    <= 1'b1;
            end else if (!cont_q) begin
              rem <= rem - ONE;
              if (rem == ONE) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end
            end
          end else if (stop) begin
            stop_pend <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !cfg_cont && (cfg_count == '0)) |=> (done && !busy)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_STEP_GATES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_mode && !step) |=> $stable(rem)); // R8
  AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    take_last |=> (!busy && done)); // R5
endmodule

// File: rtl/trc_stream_reg.sv
module trc_stream_reg #(
  parameter int NUM_PINS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                take_last,
  input  logic [NUM_PINS-1:0] word,
  input  logic                clr_ovf,
  input  logic                tready,
  output logic                tvalid,
  output logic [NUM_PINS-1:0] tdata,
  output logic                tlast,
  output logic                overflow
);
  logic stalled;
  assign stalled = tvalid && !tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvalid   <= 1'b0;
      tdata    <= '0;
      tlast    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (clr_ovf) overflow <= 1'b0;
      if (take) begin
        if (stalled) begin
          overflow <= 1'b1;
        end else begin
          tdata  <= word;
          tlast  <= take_last;
          tvalid <= 1'b1;
        end
      end else if (tvalid && tready) begin
        tvalid <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> (tvalid && $stable(tdata) && $stable(tlast))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow); // R9
  AST_ACCEPT_AND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tvalid && tready && !overflow) |=> (tvalid && !overflow)); // R10
endmodule

// File: rtl/trc_capture.sv
module trc_capture #(
  parameter int NUM_PINS = 20,
  parameter int NUM_SRC  = 3,
  parameter int CNT_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sample_tick,
  input  logic [NUM_PINS-1:0]         pin_in,
  input  logic [NUM_PINS-1:0]         pin_out,
  input  logic [NUM_PINS-1:0]         pin_hiz,
  input  logic [NUM_SRC*NUM_PINS-1:0] src_mask,
  input  logic                        trace_wr,
  input  logic [NUM_SRC-1:0]          trace_wdata,
  input  logic                        start,
  input  logic                        stop,
  input  logic [CNT_W-1:0]            cfg_count,
  input  logic                        cfg_cont,
  input  logic                        step_mode,
  input  logic                        step,
  output logic                        busy,
  output logic                        done,
  output logic                        overflow,
  output logic                        m_tvalid,
  input  logic                        m_tready,
  output logic [NUM_PINS-1:0]         m_tdata,
  output logic                        m_tlast
);
  logic [NUM_SRC-1:0]  trace_en;
  logic [NUM_PINS-1:0] sel_word;
  logic                take;
  logic                take_last;
  logic                start_ok;

  // tracing on for every source out of reset
  always_ff @(posedge clk) begin
    if (!rst_n)        trace_en <= '1;
    else if (trace_wr) trace_en <= trace_wdata;
  end

  trc_pin_select #(.NUM_PINS(NUM_PINS), .NUM_SRC(NUM_SRC)) u_sel (
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_hiz  (pin_hiz),
    .src_mask (src_mask),
    .trace_en (trace_en),
    .word     (sel_word)
  );

  trc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .cfg_count (cfg_count),
    .cfg_cont  (cfg_cont),
    .step_mode (step_mode),
    .step      (step),
    .tick      (sample_tick),
    .take      (take),
    .take_last (take_last),
    .start_ok  (start_ok),
    .busy      (busy),
    .done      (done)
  );

  trc_stream_reg #(.NUM_PINS(NUM_PINS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_last (take_last),
    .word      (sel_word),
    .clr_ovf   (start_ok),
    .tready    (m_tready),
    .tvalid    (m_tvalid),
    .tdata     (m_tdata),
    .tlast     (m_tlast),
    .overflow  (overflow)
  );

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |-> !start_ok); // R11
endmodule

// File: tb/tb_trc_capture.sv
module tb_trc_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 20;
  localparam int NS = 3;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic [NP-1:0] pin_in = '0, pin_out = '0, pin_hiz = '0;
  logic [NS*NP-1:0] src_mask;
  logic trace_wr = 1'b0;
  logic [NS-1:0] trace_wdata = '0;
  logic start = 1'b0, stop = 1'b0, cfg_cont = 1'b0, step_mode = 1'b0, step = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic busy, done, overflow, m_tvalid, m_tlast;
  logic m_tready = 1'b1;
  logic [NP-1:0] m_tdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string cur_req = "R1";
  logic [NS-1:0] model_ten = '1;
  logic [NP:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // source 0 owns pins 0..7, source 1 pins 8..15, source 2 pins 16..19
  initial begin
    src_mask = '0;
    for (int p = 0; p < NP; p++) begin
      if (p < 8)       src_mask[0*NP + p] = 1'b1;
      else if (p < 16) src_mask[1*NP + p] = 1'b1;
      else             src_mask[2*NP + p] = 1'b1;
    end
  end

  trc_capture #(.NUM_PINS(NP), .NUM_SRC(NS), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .pin_in(pin_in), .pin_out(pin_out), .pin_hiz(pin_hiz), .src_mask(src_mask),
    .trace_wr(trace_wr), .trace_wdata(trace_wdata),
    .start(start), .stop(stop), .cfg_count(cfg_count), .cfg_cont(cfg_cont),
    .step_mode(step_mode), .step(step),
    .busy(busy), .done(done), .overflow(overflow),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] model_word(input logic [NP-1:0] i, input logic [NP-1:0] o,
                                               input logic [NP-1:0] h, input logic [NS-1:0] en);
    logic [NP-1:0] w = '0;
    for (int p = 0; p < NP; p++) begin
      bit owned = 1'b0;
      for (int s = 0; s < NS; s++) if (src_mask[s*NP + p] && en[s]) owned = 1'b1;
      if (owned) w[p] = h[p] ? i[p] : o[p];
    end
    return w;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // driver: one sample event; pushes the expected word when a sample is due
  task automatic send_evt(input bit use_step, input bit expect_word, input bit last);
    pin_in  = NP'($urandom);
    pin_out = NP'($urandom);
    pin_hiz = NP'($urandom);
    if (use_step) step = 1'b1; else sample_tick = 1'b1;
    if (expect_word) exp_q.push_back({last, model_word(pin_in, pin_out, pin_hiz, model_ten)});
    cyc();
    step = 1'b0;
    sample_tick = 1'b0;
  endtask

  task automatic begin_run(input logic [CW-1:0] n, input bit cont);
    cfg_count = n;
    cfg_cont  = cont;
    start = 1'b1;
    cyc();
    start = 1'b0;
  endtask

  // monitor: pops and compares at each handshake
  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_req, " unexpected word"}, 32'(m_tdata), 32'hFFFFFFFF);
      end else begin
        logic [NP:0] e;
        e = exp_q.pop_front();
        check(m_tdata == e[NP-1:0], {cur_req, " data"}, 32'(m_tdata), 32'(e[NP-1:0]));
        check(m_tlast == e[NP], {cur_req, " last"}, 32'(m_tlast), 32'(e[NP]));
      end
    end
  end

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    check(m_tvalid == 0 && busy == 0 && done == 0 && overflow == 0, "R1",
          {m_tvalid, busy, done, overflow}, 0);
    rst_n = 1'b1;
    cyc();

    // R2 R3 R4 R5: single-shot, four samples, default trace enables
    cur_req = "R2/R4/R5";
    begin_run(4, 0);
    check(busy == 1, "R4 busy", busy, 1);
    for (int k = 0; k < 4; k++) begin
      send_evt(0, 1, k == 3);
      if (k < 3) check(busy == 1 && done == 0, "R4 running", {busy, done}, 2);
      cyc();
    end
    check(done == 0 && busy == 0, "R4 idle", {busy, done}, 0);

    // done coincides with final word
    begin_run(1, 0);
    send_evt(0, 1, 1);
    check(done == 1 && busy == 0 && m_tvalid == 1 && m_tlast == 1, "R4 done",
          {done, busy, m_tvalid, m_tlast}, 4'b1011);
    cyc();
    check(done == 0, "R4 pulse", done, 0);

    // R3 trace enable mask
    cur_req = "R3";
    trace_wdata = 3'b101; trace_wr = 1'b1; cyc(); trace_wr = 1'b0;
    model_ten = 3'b101;
    begin_run(2, 0);
    send_evt(0, 1, 0);
    send_evt(0, 1, 1);
    cyc();
    trace_wdata = 3'b111; trace_wr = 1'b1; cyc(); trace_wr = 1'b0;
    model_ten = 3'b111;

    // R6 zero count
    cur_req = "R6";
    begin_run(0, 0);
    check(done == 1 && busy == 0, "R6", {done, busy}, 2);
    send_evt(0, 0, 0);
    check(busy == 0 && m_tvalid == 0, "R6 no word", {busy, m_tvalid}, 0);

    // R7 stop waits for next tick, emits nothing
    cur_req = "R7";
    begin_run(10, 0);
    send_evt(0, 1, 0);
    send_evt(0, 1, 0);
    stop = 1'b1; cyc(); stop = 1'b0;
    cyc();
    check(busy == 1, "R7 waits for tick", busy, 1);
    send_evt(0, 0, 0);
    check(done == 1 && busy == 0, "R7 done", {done, busy}, 2);
    cyc();
    // stop and tick in the same cycle
    begin_run(5, 0);
    stop = 1'b1;
    send_evt(0, 0, 0);
    stop = 1'b0;
    check(done == 1 && busy == 0 && m_tvalid == 0, "R7 same cycle", {done, busy, m_tvalid}, 4);

    // R8 step mode ignores ticks
    cur_req = "R8";
    step_mode = 1'b1;
    begin_run(3, 0);
    send_evt(0, 0, 0);
    check(m_tvalid == 0 && busy == 1, "R8 tick ignored", {m_tvalid, busy}, 1);
    for (int k = 0; k < 3; k++) begin
      send_evt(1, 1, k == 2);
      cyc();
    end
    check(busy == 0, "R8 end", busy, 0);
    step_mode = 1'b0;

    // R9 back-pressure: held word stable, next sample dropped
    cur_req = "R9";
    m_tready = 1'b0;
    begin_run(2, 0);
    send_evt(0, 1, 0);
    begin
      logic [NP-1:0] held;
      held = m_tdata;
      cyc(); cyc();
      check(m_tvalid == 1 && m_tdata == held, "R9 hold", 32'(m_tdata), 32'(held));
    end
    send_evt(0, 0, 0);
    check(overflow == 1 && done == 1, "R9 overflow", {overflow, done}, 3);
    cyc();
    check(overflow == 1, "R9 sticky", overflow, 1);
    m_tready = 1'b1;
    cyc();

    // R10 accept and new sample in the same cycle; start clears overflow
    cur_req = "R10";
    m_tready = 1'b0;
    begin_run(2, 0);
    check(overflow == 0, "R9 clear on start", overflow, 0);
    send_evt(0, 1, 0);
    m_tready = 1'b1;
    send_evt(0, 1, 1);
    check(overflow == 0 && m_tvalid == 1, "R10", {overflow, m_tvalid}, 1);
    cyc(); cyc();

    // R11 start while busy ignored
    cur_req = "R11";
    begin_run(3, 0);
    send_evt(0, 1, 0);
    begin_run(1, 0);
    check(busy == 1, "R11 still busy", busy, 1);
    send_evt(0, 1, 0);
    check(busy == 1, "R11 count kept", busy, 1);
    send_evt(0, 1, 1);
    check(busy == 0 && done == 1, "R11 end", {busy, done}, 1);
    cyc();

    // R12 continuous ignores count
    cur_req = "R12";
    begin_run(2, 1);
    for (int k = 0; k < 4; k++) begin
      send_evt(0, 1, 0);
      cyc();
    end
    check(busy == 1, "R12 runs on", busy, 1);
    stop = 1'b1;
    send_evt(0, 0, 0);
    stop = 1'b0;
    check(done == 1 && busy == 0, "R12 stopped", {done, busy}, 2);
    repeat (3) cyc();

    check(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
    finish_sim();
  end
endmodule